// File: doc/BRIEF.md
# LNB Supply Control Register Target on I2C

This block is the serial control front end of an LNB power-supply controller. It is an I2C target that holds one 8-bit system register. A write sets six control bits, and these bits drive the supply and the tone logic directly: pulsed current limiting, tone arming, continuous tone, line-drop compensation, high voltage select and power enable. A read returns a status byte. That byte carries three of the control bits as they were last written, the over-temperature and overload fault flags, and three test positions that always read as zero.

The bus lines are oversampled by a system clock that runs at least 16 times faster than the bus bit rate. A single strap input picks one of two device addresses. While the supply-lockout input is high, the register is held at zero and the target does not answer on the bus. A read keeps sending the status byte again for as long as the master acknowledges each byte.

Top module: `lnb_ctl_i2c_target`

## Requirements
- R1: The target acknowledges the 7-bit address 0001010 when `addr_sel_i` is 0 and 0001011 when it is 1. The eighth address bit selects the direction: 1 is a read, 0 is a write. Any other address gets no acknowledge and leaves the register unchanged.
- R2: A written byte, MSB first, sets the control outputs from bit 7 down to bit 2 in this order: `pulse_lim_o`, `tone_arm_o`, `tone_cont_o`, `line_comp_o`, `volt_hi_o`, `power_en_o`. Bits 1 and 0 are discarded.
- R3: A read returns, MSB first, the byte {0, 0, 0, `line_comp_o`, `volt_hi_o`, `power_en_o`, `overtemp_i`, `overload_i`}.
- R4: After reset, every control output is 0 and SDA is released.
- R5: While `lockout_i` is high, every control output is 0, SDA is never pulled low and writes have no effect. The value stays 0 after lockout is removed.
- R6: The target pulls SDA low during the ninth clock that follows a matching address byte and during the ninth clock that follows each written data byte.
- R7: During a read, a master acknowledge on the ninth clock starts another copy of the status byte. A master not-acknowledge ends the read and releases SDA.
- R8: A START or a STOP that arrives in the middle of a byte aborts the transfer, and the partial byte is not written.
- R9: `sda_pull_o` changes only while the synchronized SCL is low, except when lockout forces it off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| addr_sel_i | input | 1 | Address strap, selects the address LSB |
| lockout_i | input | 1 | Supply lockout, holds the register clear and silences the target |
| overtemp_i | input | 1 | Over-temperature fault flag |
| overload_i | input | 1 | Output overload fault flag |
| sda_pull_o | output | 1 | Open-drain pull-down enable for SDA |
| pulse_lim_o | output | 1 | Pulsed (dynamic) current limit select |
| tone_arm_o | output | 1 | Tone output stage arm |
| tone_cont_o | output | 1 | Continuous tone enable |
| line_comp_o | output | 1 | Line-drop voltage boost |
| volt_hi_o | output | 1 | High output voltage select |
| power_en_o | output | 1 | Power block enable |

## Verification
The bench builds the block with its default parameters: two synchronizer stages, an 8-bit register and a 6-bit stored field. It runs a bus bit time of 80 system clocks. That margin is far larger than the synchronizer latency, so every acknowledge and every read bit can be sampled in the middle of the SCL high phase. With these defaults, one short run covers both strap addresses, every control-bit position, a read that repeats over several bytes, and aborts in the middle of a byte.

// File: rtl/lnb_i2c_pkg.sv
package lnb_i2c_pkg;
  localparam int BYTE_W  = 8;
  localparam int ADDR_W  = 7;
  localparam int CTL_W   = 6;
  localparam logic [ADDR_W-2:0] ADDR_HI = 6'b000101;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WDATA, ST_WDATA_ACK, ST_RDATA, ST_RDATA_ACK
  } eng_state_t;

  typedef struct packed {
    logic pulse_lim;
    logic tone_arm;
    logic tone_cont;
    logic line_comp;
    logic volt_hi;
    logic power_en;
  } ctl_t;
endpackage

// File: rtl/lnb_i2c_sync.sv
module lnb_i2c_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_d  <= scl_sh[STAGES-1];
      sda_d  <= sda_sh[STAGES-1];
    end
  end

  assign scl_lvl   = scl_sh[STAGES-1];
  assign sda_lvl   = sda_sh[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_d;
  assign scl_fall  = ~scl_lvl & scl_d;
  assign bus_start = scl_lvl & scl_d & sda_d & ~sda_lvl;
  assign bus_stop  = scl_lvl & scl_d & ~sda_d & sda_lvl;
endmodule

// File: rtl/lnb_i2c_engine.sv
module lnb_i2c_engine
  import lnb_i2c_pkg::*;
#(
  parameter int DATA_W = BYTE_W,
  parameter int KEEP_W = CTL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lockout,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic [DATA_W-2:0] dev_addr,
  input  logic [DATA_W-1:0] status_byte,
  output logic              sda_pull,
  output logic              wr_stb,
  output logic [KEEP_W-1:0] wr_keep,
  output logic              idle
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W-1);

  eng_state_t        st;
  logic [CNT_W-1:0]  bit_n;
  logic [DATA_W-1:0] sh;
  logic              full, is_rd, m_ack;

  always_ff @(posedge clk) begin
    wr_stb <= 1'b0;
    if (rst || lockout) begin
      st <= ST_IDLE; sda_pull <= 1'b0; bit_n <= '0; full <= 1'b0;
      sh <= '0; is_rd <= 1'b0; m_ack <= 1'b0; wr_keep <= '0;
    end else if (bus_start) begin
      st <= ST_ADDR; bit_n <= '0; full <= 1'b0; sda_pull <= 1'b0;
    end else if (bus_stop) begin
      st <= ST_IDLE; sda_pull <= 1'b0; full <= 1'b0;
    end else begin
      case (st)
        ST_ADDR, ST_WDATA: begin
          if (scl_rise && !full) begin
            sh <= {sh[DATA_W-2:0], sda_lvl};
            if (bit_n == LAST) full <= 1'b1;
            else               bit_n <= bit_n + 1'b1;
          end else if (scl_fall && full) begin
            full  <= 1'b0;
            bit_n <= '0;
            if (st == ST_ADDR) begin
              if (sh[DATA_W-1:1] == dev_addr) begin
                sda_pull <= 1'b1;
                is_rd    <= sh[0];
                st       <= ST_ADDR_ACK;
              end else begin
                st <= ST_IDLE;
              end
            end else begin
              wr_stb   <= 1'b1;
              wr_keep  <= sh[DATA_W-1 -: KEEP_W];
              sda_pull <= 1'b1;
              st       <= ST_WDATA_ACK;
            end
          end
        end
        ST_ADDR_ACK: if (scl_fall) begin
          if (is_rd) begin
            sh       <= status_byte;
            sda_pull <= ~status_byte[DATA_W-1];
            st       <= ST_RDATA;
          end else begin
            sda_pull <= 1'b0;
            st       <= ST_WDATA;
          end
        end
        ST_WDATA_ACK: if (scl_fall) begin
          sda_pull <= 1'b0;
          st       <= ST_WDATA;
        end
        ST_RDATA: if (scl_fall) begin
          if (bit_n == LAST) begin
            sda_pull <= 1'b0;
            bit_n    <= '0;
            st       <= ST_RDATA_ACK;
          end else begin
            bit_n    <= bit_n + 1'b1;
            sh       <= sh << 1;
            sda_pull <= ~sh[DATA_W-2];
          end
        end
        ST_RDATA_ACK: begin
          if (scl_rise) m_ack <= ~sda_lvl;
          else if (scl_fall) begin
            if (m_ack) begin
              sh       <= status_byte;
              sda_pull <= ~status_byte[DATA_W-1];
              st       <= ST_RDATA;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign idle = (st == ST_IDLE);
endmodule

// File: rtl/lnb_ctl_reg.sv
module lnb_ctl_reg #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         lockout,
  input  logic         wr_stb,
  input  logic [W-1:0] wr_bits,
  output logic [W-1:0] ctl_q
);
  always_ff @(posedge clk) begin
    if (rst || lockout) ctl_q <= '0;
    else if (wr_stb)    ctl_q <= wr_bits;
  end
endmodule

// File: rtl/lnb_ctl_i2c_target.sv
module lnb_ctl_i2c_target
  import lnb_i2c_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  input  logic addr_sel_i,
  input  logic lockout_i,
  input  logic overtemp_i,
  input  logic overload_i,
  output logic sda_pull_o,
  output logic pulse_lim_o,
  output logic tone_arm_o,
  output logic tone_cont_o,
  output logic line_comp_o,
  output logic volt_hi_o,
  output logic power_en_o
);
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, bus_start, bus_stop;
  logic wr_stb, fsm_idle;
  logic [CTL_W-1:0] wr_keep, ctl_bits;
  ctl_t ctl;
  logic [BYTE_W-1:0] status_byte;

  lnb_i2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .bus_start(bus_start), .bus_stop(bus_stop)
  );

  assign ctl = ctl_t'(ctl_bits);
  assign status_byte = {3'b000, ctl.line_comp, ctl.volt_hi, ctl.power_en,
                        overtemp_i, overload_i};

  lnb_i2c_engine #(.DATA_W(BYTE_W), .KEEP_W(CTL_W)) u_eng (
    .clk(clk), .rst(rst), .lockout(lockout_i), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .bus_start(bus_start),
    .bus_stop(bus_stop), .dev_addr({ADDR_HI, addr_sel_i}),
    .status_byte(status_byte), .sda_pull(sda_pull_o), .wr_stb(wr_stb),
    .wr_keep(wr_keep), .idle(fsm_idle)
  );

  lnb_ctl_reg #(.W(CTL_W)) u_reg (
    .clk(clk), .rst(rst), .lockout(lockout_i), .wr_stb(wr_stb),
    .wr_bits(wr_keep), .ctl_q(ctl_bits)
  );

  assign pulse_lim_o = ctl.pulse_lim;
  assign tone_arm_o  = ctl.tone_arm;
  assign tone_cont_o = ctl.tone_cont;
  assign line_comp_o = ctl.line_comp;
  assign volt_hi_o   = ctl.volt_hi;
  assign power_en_o  = ctl.power_en;
endmodule

// File: rtl/lnb_ctl_i2c_chk.sv
module lnb_ctl_i2c_chk (
  input logic       clk,
  input logic       rst,
  input logic       lockout_i,
  input logic       scl_lvl,
  input logic       sda_pull_o,
  input logic       fsm_idle,
  input logic [5:0] ctl_bits
);
  // R9: pull-down edges happen only in the SCL low phase
  assert_pull_scl_low_R9: assert property (@(posedge clk) disable iff (rst || lockout_i)
    !$stable(sda_pull_o) |-> !scl_lvl);

  // R2: control bits are committed only while SCL is low
  assert_ctl_commit_low_R2: assert property (@(posedge clk) disable iff (rst)
    (!$stable(ctl_bits) && !$past(lockout_i) && !lockout_i) |-> !scl_lvl);

  // R5: lockout clears the register and releases SDA
  assert_lockout_clear_R5: assert property (@(posedge clk) disable iff (rst)
    lockout_i |=> (ctl_bits == 6'd0) && !sda_pull_o);

  // R5: lockout parks the bus engine
  assert_lockout_idle_R5: assert property (@(posedge clk) disable iff (rst)
    lockout_i |=> fsm_idle);

  // R7: an idle engine never holds SDA
  assert_idle_release_R7: assert property (@(posedge clk) disable iff (rst)
    (fsm_idle && $past(fsm_idle)) |-> !sda_pull_o);
endmodule

bind lnb_ctl_i2c_target lnb_ctl_i2c_chk u_chk (
  .clk(clk), .rst(rst), .lockout_i(lockout_i), .scl_lvl(scl_lvl),
  .sda_pull_o(sda_pull_o), .fsm_idle(fsm_idle), .ctl_bits(ctl_bits)
);

// File: tb/sim_lnb_ctl_i2c_target.sv
`timescale 1ns/1ps
module sim_lnb_ctl_i2c_target;
  localparam int Q = 20;
  localparam int NV = 7;
  // {strap, overtemp, overload, data byte}
  localparam logic [10:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b0, 8'hFC}, {1'b1, 1'b1, 1'b0, 8'h04},
    {1'b0, 1'b0, 1'b1, 8'h08}, {1'b1, 1'b1, 1'b1, 8'h10},
    {1'b0, 1'b0, 1'b0, 8'hAB}, {1'b1, 1'b1, 1'b1, 8'h57},
    {1'b0, 1'b0, 1'b0, 8'h00}};

  logic clk = 0, rst = 1;
  logic m_scl = 1, m_sda = 1;
  logic strap = 0, lock = 0, ot = 0, ol = 0;
  logic sda_pull, p_lim, t_arm, t_cont, l_comp, v_hi, p_en;
  wire  sda_line = m_sda & ~sda_pull;
  int   n_chk = 0, n_fail = 0;
  bit   done = 0;

  always #5 clk = ~clk;

  lnb_ctl_i2c_target u0 (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line),
    .addr_sel_i(strap), .lockout_i(lock), .overtemp_i(ot), .overload_i(ol),
    .sda_pull_o(sda_pull), .pulse_lim_o(p_lim), .tone_arm_o(t_arm),
    .tone_cont_o(t_cont), .line_comp_o(l_comp), .volt_hi_o(v_hi),
    .power_en_o(p_en));

  function automatic logic [5:0] outs();
    return {p_lim, t_arm, t_cont, l_comp, v_hi, p_en};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    m_sda = 1; wq(); m_scl = 1; wq(); m_sda = 0; wq(); m_scl = 0; wq();
  endtask
  task automatic bus_stop();
    m_sda = 0; wq(); m_scl = 1; wq(); m_sda = 1; wq();
  endtask
  task automatic bit_out(input logic b);
    m_sda = b; wq(); m_scl = 1; wq(); wq(); m_scl = 0; wq();
  endtask
  task automatic bit_in(output logic b);
    logic early;
    m_sda = 1; wq(); m_scl = 1; wq(); early = sda_line; wq(); b = sda_line;
    chk("R9 sda stable while scl high", b, early);
    m_scl = 0; wq();
  endtask
  task automatic wr_byte(input logic [7:0] d, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(a); ack = ~a;
  endtask
  task automatic rd_byte(input logic give_ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) bit_in(d[i]);
    bit_out(~give_ack);
  endtask

  function automatic logic [7:0] adr(input logic s, input logic rd);
    return {6'b000101, s, rd};
  endfunction

  task automatic do_write(input logic [7:0] d, output logic a0, output logic a1);
    bus_start(); wr_byte(adr(strap, 0), a0); wr_byte(d, a1); bus_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic a0, a1;
    logic [7:0] rb, rb2;
    repeat (5) @(negedge clk);
    rst = 0;
    repeat (5) @(negedge clk);
    chk("R4 outputs after reset", outs(), 6'd0);
    chk("R4 sda released after reset", sda_pull, 1'b0);

    // table walk: write, check outputs, read back
    for (int v = 0; v < NV; v++) begin
      strap = VEC[v][10]; ot = VEC[v][9]; ol = VEC[v][8];
      do_write(VEC[v][7:0], a0, a1);
      chk("R1 address ack on write", a0, 1'b1);
      chk("R6 data byte ack", a1, 1'b1);
      chk("R2 control outputs", outs(), VEC[v][7:2]);
      bus_start(); wr_byte(adr(strap, 1), a0);
      rd_byte(1'b0, rb); bus_stop();
      chk("R1 address ack on read", a0, 1'b1);
      chk("R3 status byte", rb, {3'b000, VEC[v][4:2], VEC[v][9], VEC[v][8]});
    end

    // R1: wrong address ignored
    strap = 0; ot = 0; ol = 0;
    do_write(8'h24, a0, a1);
    bus_start(); wr_byte(adr(1'b1, 0), a0); wr_byte(8'hFC, a1); bus_stop();
    chk("R1 foreign address not acked", a0, 1'b0);
    chk("R1 foreign address no write", outs(), 6'h09);

    // R2: discarded low bits do not appear in the read byte
    do_write(8'h03, a0, a1);
    bus_start(); wr_byte(adr(strap, 1), a0); rd_byte(1'b0, rb); bus_stop();
    chk("R2 low bits discarded", rb, 8'h00);
    chk("R2 low bits give no output", outs(), 6'h00);

    // R7: repeated status bytes while master acks
    ol = 1;
    do_write(8'h1C, a0, a1);
    bus_start(); wr_byte(adr(strap, 1), a0);
    rd_byte(1'b1, rb); rd_byte(1'b1, rb2);
    chk("R7 first read byte", rb, 8'h1D);
    chk("R7 repeated read byte", rb2, 8'h1D);
    rd_byte(1'b0, rb);
    chk("R7 third byte before nack", rb, 8'h1D);
    repeat (10) @(negedge clk);
    chk("R7 sda released after nack", sda_pull, 1'b0);
    bus_stop();

    // R8: START in the middle of a data byte
    do_write(8'h80, a0, a1);
    bus_start(); wr_byte(adr(strap, 0), a0);
    for (int i = 0; i < 4; i++) bit_out(1'b0);
    bus_start(); bus_stop();
    chk("R8 start mid-byte no commit", outs(), 6'h20);
    // R8: STOP in the middle of a data byte
    bus_start(); wr_byte(adr(strap, 0), a0);
    for (int i = 0; i < 5; i++) bit_out(1'b1);
    bus_stop();
    chk("R8 stop mid-byte no commit", outs(), 6'h20);

    // R5: lockout
    do_write(8'hFC, a0, a1);
    lock = 1; repeat (4) @(negedge clk);
    chk("R5 lockout clears outputs", outs(), 6'h00);
    do_write(8'hFC, a0, a1);
    chk("R5 no ack in lockout", a0, 1'b0);
    chk("R5 write ignored in lockout", outs(), 6'h00);
    lock = 0; repeat (4) @(negedge clk);
    chk("R5 stays clear after lockout", outs(), 6'h00);
    do_write(8'h44, a0, a1);
    chk("R5 ack restored after lockout", a0, 1'b1);
    chk("R5 write works after lockout", outs(), 6'h11);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule